// File: doc/BRIEF.md
# Multitap Six-Button Pad Scanner

This block runs a host-side scan of a five-way controller tap. It drives the tap's clear line and its select line. It then reads back a 4-bit data nibble at each select level, and works out from that data what kind of pad sits on each port. A single start pulse begins a run of two passes. Each pass clears the tap and then walks every port with one low and one high phase of the select line. After every change on either line, the block waits a programmable number of clocks before it samples.

The pad type is not read from any identification register. It is inferred from the data. A six-button pad alternates between two halves of its state on successive tap clears. In one half it shows an all-zero nibble while select is high, and its select-low nibble then carries the extra buttons. A two-button pad never shows that zero pattern. Over the two passes the block therefore sees both halves of any six-button pad. At the end of the run it publishes, for each port, a valid flag, a six-button flag and a 12-bit button word, together with a one-cycle done strobe.

Top module: `mt_pad_scanner`

## Requirements
- R1: After reset and whenever no run is in progress, tap_sel is 1, tap_clr is 0 and busy is 0. Reset clears port_valid, port_six and port_buttons to zero.
- R2: A start pulse while idle raises busy and tap_clr in the next cycle. Each run makes exactly two passes. Each pass begins with one pulse of tap_clr, and tap_sel is held high during that pulse.
- R3: Each pass gives NPORTS falling and NPORTS rising edges on tap_sel (10 toggles with five ports). Ports are visited in order, and port p is read on the select-high and select-low phases that follow the p-th rising edge of tap_sel after the clear.
- R4: With S the value of settle_cycles captured at start, every tap_clr high pulse lasts exactly S+1 clocks. Every tap_sel low phase also lasts S+1 clocks, and pad_data is sampled in the last clock of each phase.
- R5: A port whose select-high nibble is nonzero on both passes is reported as two-button: valid 1, six 0, and button word {4'h0, select-low nibble, select-high nibble} taken from the second pass.
- R6: A port whose select-high nibble is zero on exactly one pass is reported as six-button: valid 1, six 1. The button word is {extra nibble [11:8], standard select-low nibble [7:4], standard select-high nibble [3:0]}. The extra nibble is the select-low nibble from the zero pass, and the standard nibbles come from the nonzero pass. The order of the two passes makes no difference to the result.
- R7: A port whose select-high nibble is zero on both passes is reported invalid: valid 0, six 0 and button word 0.
- R8: done is high for exactly one cycle at the end of the run, and busy falls in that same cycle. The per-port outputs change only in the done cycle and otherwise hold the previous run's results.
- R9: A start pulse during a run is ignored: no extra tap clear, no extra done pulse, and the run's results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a two-pass scan when idle |
| settle_cycles | input | SW | Extra wait clocks after each tap line change, captured at start |
| pad_data | input | 4 | Data nibble returned by the tap |
| tap_clr | output | 1 | Tap clear line |
| tap_sel | output | 1 | Tap select line |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| port_valid | output | NPORTS | Port record is complete |
| port_six | output | NPORTS | Port holds a six-button pad |
| port_buttons | output | 12*NPORTS | Per-port button words, port p at bits [12p+11:12p] |

## Verification
The bench builds the block with its defaults, NPORTS = 5 and SW = 4. With those values it sweeps all 243 assignments of two-button, six-button and dead pads to the five ports. Settle values 0 to 3 are cycled across the sweep, so every port sees each pad kind next to every kind of neighbour. Six-button pads start in either half, and this covers both orders in which the zero pass can arrive. A modelled tap counts edges and clears, and a line monitor times every clear and select-low phase against S+1.

// File: rtl/mt_pad_scanner.sv
module mt_pad_scanner #(
  parameter int NPORTS = 5,
  parameter int SW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SW-1:0]        settle_cycles,
  input  logic [3:0]           pad_data,
  output logic                 tap_clr,
  output logic                 tap_sel,
  output logic                 busy,
  output logic                 done,
  output logic [NPORTS-1:0]    port_valid,
  output logic [NPORTS-1:0]    port_six,
  output logic [12*NPORTS-1:0] port_buttons
);
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [IW-1:0] LAST = IW'(NPORTS - 1);

  typedef enum logic [2:0] {S_IDLE, S_CLRH, S_CLRL, S_HI, S_LO, S_TAIL} st_t;

  st_t                 st;
  logic [SW-1:0]       cnt, settle_q;
  logic [IW-1:0]       idx;
  logic                pass, take_ext, sel_q, clr_q, done_q;
  logic [3:0]          w_hi  [NPORTS];
  logic [3:0]          w_lo  [NPORTS];
  logic [3:0]          w_ext [NPORTS];
  logic [NPORTS-1:0]   zero_seen, std_seen;
  logic [NPORTS-1:0]   valid_q, six_q;
  logic [12*NPORTS-1:0] btn_q, btn_next;

  wire waiting = (cnt != '0);

  genvar g;
  generate
    for (g = 0; g < NPORTS; g++) begin : g_word
      assign btn_next[12*g +: 12] = !std_seen[g] ? 12'h000 :
                                    zero_seen[g] ? {w_ext[g], w_lo[g], w_hi[g]} :
                                                   {4'h0, w_lo[g], w_hi[g]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      settle_q  <= '0;
      idx       <= '0;
      pass      <= 1'b0;
      take_ext  <= 1'b0;
      sel_q     <= 1'b1;
      clr_q     <= 1'b0;
      done_q    <= 1'b0;
      zero_seen <= '0;
      std_seen  <= '0;
      valid_q   <= '0;
      six_q     <= '0;
      btn_q     <= '0;
      for (int p = 0; p < NPORTS; p++) begin
        w_hi[p]  <= 4'h0;
        w_lo[p]  <= 4'h0;
        w_ext[p] <= 4'h0;
      end
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          settle_q  <= settle_cycles;
          cnt       <= settle_cycles;
          clr_q     <= 1'b1;
          pass      <= 1'b0;
          zero_seen <= '0;
          std_seen  <= '0;
          st        <= S_CLRH;
        end
        S_CLRH: if (waiting) cnt <= cnt - 1'b1;
          else begin
            clr_q <= 1'b0;
            cnt   <= settle_q;
            idx   <= '0;
            st    <= S_CLRL;
          end
        S_CLRL: if (waiting) cnt <= cnt - 1'b1;
          else st <= S_HI;
        S_HI: if (waiting) cnt <= cnt - 1'b1;
          else begin
            if (pad_data == 4'h0) begin
              zero_seen[idx] <= 1'b1;
              take_ext       <= 1'b1;
            end else begin
              std_seen[idx] <= 1'b1;
              w_hi[idx]     <= pad_data;
              take_ext      <= 1'b0;
            end
            sel_q <= 1'b0;
            cnt   <= settle_q;
            st    <= S_LO;
          end
        S_LO: if (waiting) cnt <= cnt - 1'b1;
          else begin
            if (take_ext) w_ext[idx] <= pad_data;
            else          w_lo[idx]  <= pad_data;
            sel_q <= 1'b1;
            cnt   <= settle_q;
            if (idx == LAST) st <= S_TAIL;
            else begin
              idx <= idx + 1'b1;
              st  <= S_HI;
            end
          end
        S_TAIL: if (waiting) cnt <= cnt - 1'b1;
          else if (pass) begin
            valid_q <= std_seen;
            six_q   <= std_seen & zero_seen;
            btn_q   <= btn_next;
            done_q  <= 1'b1;
            st      <= S_IDLE;
          end else begin
            pass  <= 1'b1;
            clr_q <= 1'b1;
            cnt   <= settle_q;
            st    <= S_CLRH;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tap_clr      = clr_q;
  assign tap_sel      = sel_q;
  assign busy         = (st != S_IDLE);
  assign done         = done_q;
  assign port_valid   = valid_q;
  assign port_six     = six_q;
  assign port_buttons = btn_q;
endmodule

module mt_pad_scanner_chk #(
  parameter int NPORTS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 tap_clr,
  input logic                 tap_sel,
  input logic                 busy,
  input logic                 done,
  input logic [NPORTS-1:0]    port_valid,
  input logic [NPORTS-1:0]    port_six,
  input logic [12*NPORTS-1:0] port_buttons
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tap_sel && !tap_clr)); // R1
  AST_CLR_UNDER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    tap_clr |-> tap_sel); // R2
  AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && tap_clr)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(port_buttons) && $stable(port_valid) && $stable(port_six))); // R8
  AST_SIX_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (port_six & ~port_valid) == '0); // R6
  AST_INVALID_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (port_valid != '0 || port_buttons == '0)); // R7
endmodule

bind mt_pad_scanner mt_pad_scanner_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tap_clr(tap_clr), .tap_sel(tap_sel),
  .busy(busy), .done(done), .port_valid(port_valid), .port_six(port_six),
  .port_buttons(port_buttons)
);

// File: tb/mt_pad_scanner_tb.sv
`timescale 1ns/1ps
module mt_pad_scanner_tb;
  localparam int N  = 5;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] settle = '0;
  logic [3:0] pad_data;
  logic tap_clr, tap_sel, busy, done;
  logic [N-1:0] port_valid, port_six;
  logic [12*N-1:0] port_buttons;

  always #2.5 clk = ~clk;

  mt_pad_scanner #(.NPORTS(N), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle),
    .pad_data(pad_data), .tap_clr(tap_clr), .tap_sel(tap_sel), .busy(busy),
    .done(done), .port_valid(port_valid), .port_six(port_six),
    .port_buttons(port_buttons)
  );

  // tap and pad model: 0 two-button, 1 six-button, 2 dead (high nibble always zero)
  int   ptype [N];
  logic [3:0] hi_v [N];
  logic [3:0] lo_v [N];
  logic [3:0] ex_v [N];
  logic ph_init [N];
  int   tidx = N;
  int   clr_total = 0;
  int   sel_falls = 0;
  logic pclr = 1'b0, psel = 1'b1;

  always @(tap_clr or tap_sel) begin
    if (tap_clr === 1'b1 && pclr == 1'b0) begin
      tidx = 0;
      clr_total++;
    end else if (tap_sel === 1'b1 && psel == 1'b0 && tap_clr === 1'b0) tidx++;
    if (tap_sel === 1'b0 && psel == 1'b1) sel_falls++;
    pclr = (tap_clr === 1'b1);
    psel = (tap_sel !== 1'b0);
  end

  always @* begin
    pad_data = 4'h0;
    if (tidx < N) begin
      if (ptype[tidx] == 0) pad_data = tap_sel ? hi_v[tidx] : lo_v[tidx];
      else if (ptype[tidx] == 2) pad_data = tap_sel ? 4'h0 : ex_v[tidx];
      else if (ph_init[tidx] ^ clr_total[0]) pad_data = tap_sel ? 4'h0 : ex_v[tidx];
      else pad_data = tap_sel ? hi_v[tidx] : lo_v[tidx];
    end
  end

  // line timing monitor
  int cur_s = 0;
  int bad_total = 0;
  int low_len = 0, clr_len = 0;
  logic msel = 1'b1, mclr = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tap_sel) begin
        if (!msel && low_len != cur_s + 1) bad_total++;
        low_len = 0;
      end else low_len++;
      if (!tap_clr) begin
        if (mclr && clr_len != cur_s + 1) bad_total++;
        clr_len = 0;
      end else clr_len++;
      msel = tap_sel;
      mclr = tap_clr;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [N-1:0]    e_valid = '0, e_six = '0;
  logic [12*N-1:0] e_btn = '0;

  task automatic run_combo(input int combo);
    int c0, f0, b0, wd, rest;
    logic [N-1:0] n_valid, n_six;
    logic [12*N-1:0] n_btn;
    rest = combo;
    cur_s = combo % 4;
    settle = SW'(cur_s);
    for (int p = 0; p < N; p++) begin
      ptype[p]   = rest % 3;
      rest       = rest / 3;
      hi_v[p]    = 4'(((combo + p) % 15) + 1);
      lo_v[p]    = 4'(combo * 3 + p);
      ex_v[p]    = 4'(combo * 5 + p * 7);
      ph_init[p] = 1'((combo >> p) ^ (combo >> 3));
      if (ptype[p] == 0) begin
        n_valid[p] = 1'b1; n_six[p] = 1'b0;
        n_btn[12*p +: 12] = {4'h0, lo_v[p], hi_v[p]};
      end else if (ptype[p] == 1) begin
        n_valid[p] = 1'b1; n_six[p] = 1'b1;
        n_btn[12*p +: 12] = {ex_v[p], lo_v[p], hi_v[p]};
      end else begin
        n_valid[p] = 1'b0; n_six[p] = 1'b0;
        n_btn[12*p +: 12] = 12'h000;
      end
    end
    c0 = clr_total; f0 = sel_falls; b0 = bad_total;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && tap_clr, "R2", "busy/clr after start", {busy, tap_clr}, 2'b11);
    repeat (3) @(negedge clk);
    chk(port_buttons == e_btn && port_valid == e_valid && port_six == e_six,
        "R8", "results held mid-run", int'(port_valid), int'(e_valid));
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wd = 0;
    while (!done && wd < 3000) begin @(negedge clk); wd++; end
    chk(done, "R8", "done seen", done, 1);
    chk(!busy, "R8", "busy low at done", busy, 0);
    for (int p = 0; p < N; p++) begin
      if (ptype[p] == 0) begin
        chk(port_valid[p] == n_valid[p] && port_six[p] == n_six[p] &&
            port_buttons[12*p +: 12] == n_btn[12*p +: 12], "R5", "two-button word",
            int'(port_buttons[12*p +: 12]), int'(n_btn[12*p +: 12]));
      end else if (ptype[p] == 1) begin
        chk(port_valid[p] == n_valid[p] && port_six[p] == n_six[p] &&
            port_buttons[12*p +: 12] == n_btn[12*p +: 12], "R6", "six-button word",
            int'(port_buttons[12*p +: 12]), int'(n_btn[12*p +: 12]));
      end else begin
        chk(port_valid[p] == 1'b0 && port_six[p] == 1'b0 &&
            port_buttons[12*p +: 12] == 12'h000, "R7", "dead port",
            int'({port_valid[p], port_six[p], port_buttons[12*p +: 12]}), 0);
      end
    end
    @(negedge clk);
    chk(!done, "R8", "done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(clr_total - c0 == 2, "R9", "clear pulses per run", clr_total - c0, 2);
    chk(sel_falls - f0 == 2 * N, "R3", "select falls per run", sel_falls - f0, 2 * N);
    chk(bad_total == b0, "R4", "settle phase lengths", bad_total - b0, 0);
    chk(!busy && !done && tap_sel && !tap_clr, "R1", "idle lines after run",
        {busy, done, tap_sel, tap_clr}, 4'b0010);
    e_valid = n_valid; e_six = n_six; e_btn = n_btn;
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin
      ptype[p] = 0; hi_v[p] = 4'h1; lo_v[p] = 4'h0; ex_v[p] = 4'h0; ph_init[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(tap_sel && !tap_clr && !busy && !done, "R1", "lines in reset",
        {tap_sel, tap_clr, busy, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tap_sel && !tap_clr && !busy, "R1", "idle lines", {tap_sel, tap_clr, busy}, 3'b100);
    chk(port_valid == '0 && port_six == '0 && port_buttons == '0, "R1", "reset results",
        int'(port_valid), 0);
    for (int combo = 0; combo < 243; combo++) run_combo(combo);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule